// File: doc/BRIEF.md
# DMA Request Sense Detector

This block conditions one request line that asks a single DMA channel for service, and turns it into a clean per-channel request bit for the channel arbiter. The line may come from an external pin, from a software trigger or from an on-chip peripheral. A two-bit sense field picks how the line is read: level or edge detection, with either polarity. Software-trigger sources are normally set to rising-edge sense. On-chip peripheral sources are normally set to falling-edge sense.

The request input is first brought onto the system clock by a two-flop synchronizer. In edge mode, a detected edge is held in a pending flag until the arbiter returns an acknowledge. In level mode, nothing is stored: the request bit follows the synchronized level, so the requester must keep its level until it sees the acknowledge. A single-operand transfer is a read followed by a write. In level mode, a strobe marking the start of that transfer's last write blanks the request bit for four clock cycles. This stops the requester's level, which may still be active, from starting a second transfer.

Top module: `dreq_sense_top`

## Requirements
- R1: The sense field `sense_mode_i` is decoded as follows. Bit 0 set selects level sense and bit 0 clear selects edge sense. The four codes are: 2'b00 rising edge, 2'b10 falling edge, 2'b01 active-low level, 2'b11 active-high level.
- R2: The request input passes through two flops before it is used. In level mode, `req_o` reflects an input change after the second rising clock edge that follows the change.
- R3: In level mode the request is not stored. `req_o` goes low two edges after the input leaves its active level, whether or not `ack_i` was given, and `ack_i` has no effect on it.
- R4: In edge mode, a matching transition of the input sets a pending flag on the third clock edge after the change. `req_o` shows this flag, and the flag stays set while the input keeps changing, until an acknowledge arrives.
- R5: A high `ack_i` clears the pending flag at the clock edge that samples it. If a new edge is detected in that same cycle, the flag stays set.
- R6: In level mode, a high `last_wr_i` forces `req_o` low in the strobe cycle and in the three cycles that follow, four cycles in all. After that, `req_o` follows the level again.
- R7: A new `last_wr_i` strobe during an active blanking window restarts the four-cycle count.
- R8: The blanking strobe has no effect in edge mode: a set pending flag stays visible on `req_o`.
- R9: A change of the sense field clears the pending flag. It also loads the previous-sample register with the current sample, so that switching modes while the input is steady produces no edge.
- R10: While the synchronous reset `rst` is high, `req_o` is low. Reset also clears the pending flag, the blanking counter and the synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq_i | input | 1 | Raw request line, asynchronous |
| sense_mode_i | input | 2 | Sense field selecting edge or level mode and polarity |
| ack_i | input | 1 | Acknowledge from the channel, one cycle per accepted request |
| last_wr_i | input | 1 | Strobe marking the start of the last write of a single-operand transfer |
| req_o | output | 1 | Conditioned request bit for the channel arbiter |

## Verification
In edge mode, an acknowledge that clears the pending flag can fall in the same cycle as a freshly detected edge that sets it. The bench provokes this by raising the input again right after a request was latched. It times the acknowledge so that it arrives while the synchronized sample differs from the previous one. It then expects `req_o` to remain high, and to fall only after a second, lone acknowledge. A strobe that lands inside an active blanking window is also driven. The bench judges it by finding the request still masked in the cycle where the first window alone would already have ended.

// File: rtl/dreq_sense_pkg.sv
package dreq_sense_pkg;

    typedef enum logic [1:0] {
        SENSE_EDGE_RISE  = 2'b00,
        SENSE_LEVEL_LOW  = 2'b01,
        SENSE_EDGE_FALL  = 2'b10,
        SENSE_LEVEL_HIGH = 2'b11
    } sense_mode_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } sample_pair_t;

    localparam int unsigned SYNC_DEPTH  = 2;
    localparam int unsigned BLANK_TICKS = 4;

    function automatic logic mode_is_level(sense_mode_e m);
        return m[0];
    endfunction

    // level sense: active value is bit 1; edge sense: level reached after the edge
    function automatic logic target_level(sense_mode_e m);
        return m[0] ? m[1] : ~m[1];
    endfunction

    function automatic logic edge_hit(sample_pair_t s, logic tgt);
        return (s.cur == tgt) && (s.prev != tgt);
    endfunction

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q[g] <= 1'b0;
                end else if (g == 0) begin
                    chain_q[g] <= async_i;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dreq_edge_pend.sv
module dreq_edge_pend
    import dreq_sense_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sample_i,
    input  sense_mode_e mode_i,
    input  logic        ack_i,
    output logic        pend_o
);
    logic         prev_q;
    sense_mode_e  mode_q;
    logic         pend_q;
    logic         mode_chg;
    logic         hit;
    sample_pair_t pair;

    assign pair     = '{cur: sample_i, prev: prev_q};
    assign mode_chg = (mode_i != mode_q);
    assign hit      = !mode_is_level(mode_i) && !mode_chg
                      && edge_hit(pair, target_level(mode_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            mode_q <= SENSE_EDGE_RISE;
            pend_q <= 1'b0;
        end else begin
            // previous sample always tracks; on a mode change this reseeds it
            prev_q <= sample_i;
            mode_q <= mode_i;
            if (mode_chg)
                pend_q <= 1'b0;
            else if (hit)
                pend_q <= 1'b1;
            else if (ack_i)
                pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R5
    edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> pend_o);
    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !hit) |=> !pend_o);
    // R9
    mode_flush_chk: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> !pend_o);
endmodule

// File: rtl/dreq_blank_timer.sv
module dreq_blank_timer #(
    parameter int unsigned BLANK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic blank_o
);
    localparam int unsigned CW = $clog2(BLANK_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(BLANK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (strobe_i)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign blank_o = strobe_i || (cnt_q != '0);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> (cnt_q == RELOAD));
    // R6
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= RELOAD);
endmodule

// File: rtl/dreq_sense_top.sv
module dreq_sense_top
    import dreq_sense_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = SYNC_DEPTH,
    parameter int unsigned BLANK_CYCLES = BLANK_TICKS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dreq_i,
    input  logic [1:0] sense_mode_i,
    input  logic       ack_i,
    input  logic       last_wr_i,
    output logic       req_o
);
    sense_mode_e mode;
    logic        sample;
    logic        pend;
    logic        blank;
    logic        level_sel;
    logic        level_act;

    assign mode      = sense_mode_e'(sense_mode_i);
    assign level_sel = mode_is_level(mode);

    dreq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (dreq_i),
        .sync_o  (sample)
    );

    dreq_edge_pend pend_i (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample),
        .mode_i   (mode),
        .ack_i    (ack_i),
        .pend_o   (pend)
    );

    dreq_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) blank_i (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (last_wr_i),
        .blank_o  (blank)
    );

    assign level_act = (sample == target_level(mode)) && !blank;
    assign req_o     = !rst && (level_sel ? level_act : pend);

    // R10
    always_comb begin
        if (rst) begin
            rst_quiet_chk: assert (!req_o);
        end
    end

    // R6
    level_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (level_sel && blank) |-> !req_o);
    // R8
    edge_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        (!level_sel && pend) |-> req_o);
endmodule

// File: tb/dreq_sense_top_tb_top.sv
module dreq_sense_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       dreq_i;
    logic [1:0] sense_mode_i;
    logic       ack_i;
    logic       last_wr_i;
    logic       req_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dreq_sense_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .dreq_i       (dreq_i),
        .sense_mode_i (sense_mode_i),
        .ack_i        (ack_i),
        .last_wr_i    (last_wr_i),
        .req_o        (req_o)
    );

    // row: {mode[1:0], dreq, ack, last_wr, expected req_o after the edge}
    localparam int NV = 28;
    localparam logic [5:0] VEC [NV] = '{
        6'b00_0_0_0_0, // R4 idle rising mode
        6'b00_1_0_0_0, // R2 first flop only
        6'b00_1_0_0_0, // R4 edge seen, not yet latched
        6'b00_1_0_0_1, // R4 pending set
        6'b00_1_0_0_1, // R4 held
        6'b00_1_1_0_0, // R5 ack clears
        6'b00_0_0_0_0,
        6'b00_0_0_0_0, // R1 falling transition ignored in rising mode
        6'b10_0_0_0_0, // R9 switch to falling edge
        6'b10_1_0_0_0,
        6'b10_1_0_0_0, // R1 rising ignored in falling mode
        6'b10_0_0_0_0,
        6'b10_0_0_0_0,
        6'b10_0_0_0_1, // R1 falling edge latched
        6'b10_0_1_0_0, // R5 ack clears
        6'b11_0_0_0_0, // R1 active-high level, idle
        6'b11_1_0_0_0, // R2 one flop in
        6'b11_1_0_0_1, // R2 level visible
        6'b11_1_0_1_0, // R6 strobe masks
        6'b11_1_0_0_0, // R6
        6'b11_1_0_0_0, // R6
        6'b11_1_0_0_1, // R6 window over
        6'b01_1_0_0_0, // R1 active-low, input high
        6'b01_0_0_0_0,
        6'b01_0_0_0_1, // R1 low level requests
        6'b01_0_1_0_1, // R3 ack has no effect
        6'b01_1_0_0_1,
        6'b01_1_0_0_0  // R3 not stored
    };

    task automatic check(input logic exp, input string tag);
        checks++;
        if (req_o !== exp) begin
            errors++;
            $display("FAIL %s: req_o=%0b expected %0b (t=%0t)", tag, req_o, exp, $time);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic d, input logic a, input logic l);
        sense_mode_i = m;
        dreq_i       = d;
        ack_i        = a;
        last_wr_i    = l;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; dreq_i = 1'b0; sense_mode_i = 2'b01; ack_i = 1'b0; last_wr_i = 1'b0;
        @(negedge clk);
        check(1'b0, "R10 reset holds request low in active-low level mode");
        @(negedge clk);
        sense_mode_i = 2'b00;
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5:4], VEC[i][3], VEC[i][2], VEC[i][1]);
            check(VEC[i][0], $sformatf("R1/R2/R3/R4/R5/R6 table row %0d", i));
        end

        // coincident ack and new edge
        step(2'b00, 1'b1, 1'b0, 1'b0); check(1'b0, "R9 mode change to rising");
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0); check(1'b1, "R4 rising edge latched");
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0); check(1'b1, "R4 pending held after input drop");
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0); check(1'b1, "R4 pending still set");
        step(2'b00, 1'b1, 1'b1, 1'b0); check(1'b1, "R5 ack with simultaneous edge keeps pending");
        step(2'b00, 1'b1, 1'b0, 1'b0); check(1'b1, "R5 pending survives");
        step(2'b00, 1'b1, 1'b1, 1'b0); check(1'b0, "R5 lone ack clears");

        // mode switch with steady input: no false edge, pending flushed
        step(2'b10, 1'b1, 1'b0, 1'b0); check(1'b0, "R9 switch to falling");
        step(2'b10, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0); check(1'b0, "R9 no false edge after mode switch");
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0); check(1'b1, "R4 pending set before flush");
        step(2'b10, 1'b1, 1'b0, 1'b0); check(1'b0, "R9 mode change clears pending");
        step(2'b10, 1'b1, 1'b0, 1'b0); check(1'b0, "R9 stays clear");

        // blanking restart
        step(2'b11, 1'b1, 1'b0, 1'b0); check(1'b1, "R6 level high before strobe");
        step(2'b11, 1'b1, 1'b0, 1'b1); check(1'b0, "R6 first strobe masks");
        step(2'b11, 1'b1, 1'b0, 1'b0); check(1'b0, "R6 masked");
        step(2'b11, 1'b1, 1'b0, 1'b1); check(1'b0, "R7 second strobe masks");
        step(2'b11, 1'b1, 1'b0, 1'b0); check(1'b0, "R7 masked");
        step(2'b11, 1'b1, 1'b0, 1'b0); check(1'b0, "R7 restarted window still masks");
        step(2'b11, 1'b1, 1'b0, 1'b0); check(1'b1, "R7 window over");

        // strobe in edge mode
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0);
        step(2'b00, 1'b1, 1'b0, 1'b0); check(1'b1, "R4 pending before strobe");
        step(2'b00, 1'b1, 1'b0, 1'b1); check(1'b1, "R8 strobe ignored in edge mode");
        step(2'b00, 1'b1, 1'b0, 1'b0); check(1'b1, "R8 still pending");

        // reset in the middle of a pending request
        rst = 1'b1;
        step(2'b00, 1'b0, 1'b0, 1'b0); check(1'b0, "R10 reset forces low");
        rst = 1'b0;
        step(2'b00, 1'b0, 1'b0, 1'b0); check(1'b0, "R10 pending cleared by reset");
        step(2'b00, 1'b0, 1'b0, 1'b0); check(1'b0, "R10 stays clear");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule